// File: doc/BRIEF.md
# ISDN NT Layer-1 Activation Controller

This block runs the network-side activation and deactivation procedure of a basic-rate S/T interface. It tracks five states (G0 reset, G1 deactive, G2 pending activation, G3 active, G4 pending deactivation). It reacts to host requests, to received line indications decoded elsewhere, and to a T1 expiry pulse that software times. It reports which INFO signal the transmitter should send.

A built-in guard timer (T2) counts 125 µs frame ticks while the machine waits in pending deactivation. When it runs out, the machine falls back to deactive, so that a late TE cannot reactivate the line by accident. A host write can load a state and freeze the machine there, for example to pin the interface active against noisy input. Clearing the freeze bit hands control back to normal event handling. After reset the machine is frozen in G0.

Top module: `nt_l1_act`

## Requirements
- R1: After reset, state_num is 0 (G0), held is 1, tx_info is 0, t2_running is 0 and evt_error is 0.
- R2: tx_info carries the INFO number to send: 0 in G0, G1 and G4; 2 in G2; 4 in G3.
- R3: A write with frc_data[4]=0 clears held on the next clock. If the state was G0 it becomes G1; in any other state the state is unchanged.
- R4: A write with frc_data[4]=1 and frc_data[3:0] at most 4 loads state_num with frc_data[3:0] and sets held on the next clock. A write of 13h gives a held G3.
- R5: While held is 1 and no write occurs, no line event, request, T1 pulse or frame tick changes the state or raises evt_error, and t2_running stays 0.
- R6: In G1, act_req or rx_info1 moves the machine to G2. rx_info0 or deact_req leaves it in G1 without an error.
- R7: In G2, rx_info3 moves the machine to G3, and t1_expiry or deact_req moves it to G4. Entry into G3 without a write happens only from G2.
- R8: In G3, deact_req moves the machine to G4 and rx_info0 moves it to G2.
- R9: t2_running is 1 exactly while unheld in G4. The frame counter starts at zero on the first clock spent in G4, and the 256th tick counted there moves the machine to G1. act_req in G4 moves it to G2.
- R10: When several events arrive in one cycle, only one of them is handled. The order of precedence is deact_req, act_req, t1_expiry, T2 expiry, rx_info3, rx_info1, rx_info0.
- R11: evt_error pulses for one cycle, with the state unchanged, after an impossible event wins (t1_expiry outside G2, rx_info1 in G3, rx_info3 in G1) or after a hold write whose state field exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_tick | input | 1 | One-cycle pulse every 125 µs frame |
| rx_info0 | input | 1 | INFO 0 decoded on the receive line |
| rx_info1 | input | 1 | INFO 1 decoded on the receive line |
| rx_info3 | input | 1 | INFO 3 decoded on the receive line |
| act_req | input | 1 | Host activate request |
| deact_req | input | 1 | Host deactivate request |
| t1_expiry | input | 1 | T1 expiry pulse from software |
| frc_wr | input | 1 | Strobe for the state-force word |
| frc_data | input | 5 | Bit 4 is the hold bit, bits 3:0 are the state number |
| state_num | output | 3 | Current state number (0 to 4) |
| tx_info | output | 3 | INFO number to transmit |
| held | output | 1 | Machine is frozen by the host |
| t2_running | output | 1 | T2 guard timer is counting |
| evt_error | output | 1 | One-cycle pulse on an impossible event or bad write |

## Verification
A wrong internal state appears on state_num and tx_info one clock after the event that caused it. A bad guard count stays hidden until the end of the 256-frame window, where G1 arrives early or late. For this reason the T2 expiry edge is compared cycle by cycle against a behavioural model. Hold leaks are checked the same way: line events are fed while the machine is held in G0, G3 and G4, and state_num and evt_error must stay flat through the whole window.

// File: rtl/nt_act_pkg.sv
package nt_act_pkg;

    typedef enum logic [2:0] {
        ST_G0 = 3'd0,
        ST_G1 = 3'd1,
        ST_G2 = 3'd2,
        ST_G3 = 3'd3,
        ST_G4 = 3'd4
    } nt_state_e;

    // winning event of a cycle, listed in decreasing precedence
    typedef enum logic [2:0] {
        EV_NONE,
        EV_DEACT,
        EV_ACT,
        EV_T1,
        EV_T2,
        EV_INFO3,
        EV_INFO1,
        EV_INFO0
    } nt_event_e;

    typedef struct packed {
        logic       hold;
        logic [3:0] state;
    } frc_word_t;

    typedef struct packed {
        nt_state_e nxt;
        logic      err;
    } nt_step_t;

    localparam logic [3:0] ST_MAX = 4'd4;

    function automatic logic [2:0] info_code(nt_state_e s);
        case (s)
            ST_G2:   return 3'd2;
            ST_G3:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic nt_step_t nt_step(nt_state_e s, nt_event_e e);
        nt_step_t r;
        r.nxt = s;
        r.err = 1'b0;
        case (s)
            ST_G1: case (e)
                EV_ACT, EV_INFO1: r.nxt = ST_G2;
                EV_T1, EV_INFO3:  r.err = 1'b1;
                default: ;
            endcase
            ST_G2: case (e)
                EV_INFO3:         r.nxt = ST_G3;
                EV_T1, EV_DEACT:  r.nxt = ST_G4;
                default: ;
            endcase
            ST_G3: case (e)
                EV_DEACT:         r.nxt = ST_G4;
                EV_INFO0:         r.nxt = ST_G2;
                EV_T1, EV_INFO1:  r.err = 1'b1;
                default: ;
            endcase
            ST_G4: case (e)
                EV_ACT:           r.nxt = ST_G2;
                EV_T2:            r.nxt = ST_G1;
                EV_T1:            r.err = 1'b1;
                default: ;
            endcase
            default: ;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/nt_evt_arb.sv
module nt_evt_arb
    import nt_act_pkg::*;
(
    input  logic      deact,
    input  logic      act,
    input  logic      t1,
    input  logic      t2,
    input  logic      info3,
    input  logic      info1,
    input  logic      info0,
    output nt_event_e ev
);
    always_comb begin
        if (deact)      ev = EV_DEACT;
        else if (act)   ev = EV_ACT;
        else if (t1)    ev = EV_T1;
        else if (t2)    ev = EV_T2;
        else if (info3) ev = EV_INFO3;
        else if (info1) ev = EV_INFO1;
        else if (info0) ev = EV_INFO0;
        else            ev = EV_NONE;
    end
endmodule

// File: rtl/nt_t2_timer.sv
module nt_t2_timer #(
    parameter int unsigned T2_FRAMES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic tick,
    output logic expire
);
    localparam int unsigned CW = (T2_FRAMES > 1) ? $clog2(T2_FRAMES) : 1;
    localparam logic [CW-1:0] LAST = CW'(T2_FRAMES - 1);

    logic [CW-1:0] cnt;

    assign expire = run && tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= expire ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/nt_act_fsm.sv
module nt_act_fsm
    import nt_act_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  nt_event_e ev,
    input  logic      frc_wr,
    input  frc_word_t frc,
    output nt_state_e state,
    output logic      held,
    output logic      err
);
    nt_step_t step;

    assign step = nt_step(state, ev);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_G0;
            held  <= 1'b1;
            err   <= 1'b0;
        end else begin
            err <= 1'b0;
            if (frc_wr) begin
                if (frc.hold) begin
                    if (frc.state <= ST_MAX) begin
                        state <= nt_state_e'(frc.state[2:0]);
                        held  <= 1'b1;
                    end else begin
                        err <= 1'b1;
                    end
                end else begin
                    held <= 1'b0;
                    if (state == ST_G0)
                        state <= ST_G1;
                end
            end else if (!held) begin
                state <= step.nxt;
                err   <= step.err;
            end
        end
    end

    AST_RST_G0: assert property (@(posedge clk)
        rst |=> (state == ST_G0 && held && !err)); // R1

    AST_HELD_FIXED: assert property (@(posedge clk) disable iff (rst)
        (held && !frc_wr) |=> $stable(state)); // R5

    AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (rst)
        err |-> (state == $past(state))); // R11

    AST_G3_ONLY_FROM_G2: assert property (@(posedge clk) disable iff (rst)
        (!frc_wr && state != ST_G3) |=> (state != ST_G3 || $past(state) == ST_G2)); // R7
endmodule

// File: rtl/nt_l1_act.sv
module nt_l1_act
    import nt_act_pkg::*;
#(
    parameter int unsigned T2_FRAMES = 256
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       frame_tick,
    input  logic       rx_info0,
    input  logic       rx_info1,
    input  logic       rx_info3,
    input  logic       act_req,
    input  logic       deact_req,
    input  logic       t1_expiry,
    input  logic       frc_wr,
    input  logic [4:0] frc_data,
    output logic [2:0] state_num,
    output logic [2:0] tx_info,
    output logic       held,
    output logic       t2_running,
    output logic       evt_error
);
    nt_state_e state;
    nt_event_e ev;
    frc_word_t frc;
    logic      t2_exp;
    logic      run;

    assign frc        = frc_word_t'(frc_data);
    assign run        = (state == ST_G4) && !held;
    assign state_num  = state;
    assign tx_info    = info_code(state);
    assign t2_running = run;

    nt_t2_timer #(.T2_FRAMES(T2_FRAMES)) u_t2 (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .tick   (frame_tick),
        .expire (t2_exp)
    );

    nt_evt_arb u_arb (
        .deact (deact_req),
        .act   (act_req),
        .t1    (t1_expiry),
        .t2    (t2_exp),
        .info3 (rx_info3),
        .info1 (rx_info1),
        .info0 (rx_info0),
        .ev    (ev)
    );

    nt_act_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .ev     (ev),
        .frc_wr (frc_wr),
        .frc    (frc),
        .state  (state),
        .held   (held),
        .err    (evt_error)
    );

    AST_T2_TO_G1: assert property (@(posedge clk) disable iff (rst)
        (t2_exp && !frc_wr && !deact_req && !act_req && !t1_expiry) |=> (state_num == 3'd1)); // R9
endmodule

// File: tb/test_nt_l1_act.sv
module test_nt_l1_act;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick = 1'b0, i0 = 1'b0, i1 = 1'b0, i3 = 1'b0;
    logic act = 1'b0, deact = 1'b0, t1 = 1'b0, fwr = 1'b0;
    logic [4:0] fdata = '0;
    logic [2:0] state_num, tx_info;
    logic held, t2_running, evt_error;

    int checks = 0;
    int errors = 0;
    string tag = "R1";

    // reference model
    int m_st = 0;
    int m_hold = 1;
    int m_cnt = 0;
    int m_err = 0;

    always #2 clk = ~clk;

    nt_l1_act i_nt_l1_act (
        .clk(clk), .rst(rst), .frame_tick(tick),
        .rx_info0(i0), .rx_info1(i1), .rx_info3(i3),
        .act_req(act), .deact_req(deact), .t1_expiry(t1),
        .frc_wr(fwr), .frc_data(fdata),
        .state_num(state_num), .tx_info(tx_info), .held(held),
        .t2_running(t2_running), .evt_error(evt_error)
    );

    function automatic int exp_tx(int s);
        if (s == 2) return 2;
        if (s == 3) return 4;
        return 0;
    endfunction

    task automatic model_step();
        int nst = m_st, nhold = m_hold, ncnt, nerr = 0;
        bit run = (m_st == 4) && (m_hold == 0);
        bit t2x = run && tick && (m_cnt == 255);
        if (rst) begin
            m_st = 0; m_hold = 1; m_cnt = 0; m_err = 0;
            return;
        end
        ncnt = !run ? 0 : (tick ? (t2x ? 0 : m_cnt + 1) : m_cnt);
        if (fwr) begin
            if (fdata[4]) begin
                if (fdata[3:0] <= 4) begin nst = fdata[3:0]; nhold = 1; end
                else nerr = 1;
            end else begin
                nhold = 0;
                if (m_st == 0) nst = 1;
            end
        end else if (m_hold == 0) begin
            if (deact) begin
                if (m_st == 2 || m_st == 3) nst = 4;
            end else if (act) begin
                if (m_st == 1 || m_st == 4) nst = 2;
            end else if (t1) begin
                if (m_st == 2) nst = 4; else nerr = 1;
            end else if (t2x) begin
                nst = 1;
            end else if (i3) begin
                if (m_st == 2) nst = 3; else if (m_st == 1) nerr = 1;
            end else if (i1) begin
                if (m_st == 1) nst = 2; else if (m_st == 3) nerr = 1;
            end else if (i0) begin
                if (m_st == 3) nst = 2;
            end
        end
        m_st = nst; m_hold = nhold; m_cnt = ncnt; m_err = nerr;
    endtask

    task automatic compare();
        int run = (m_st == 4 && m_hold == 0) ? 1 : 0;
        checks++;
        if (state_num !== 3'(m_st) || tx_info !== 3'(exp_tx(m_st)) || held !== 1'(m_hold)
            || t2_running !== 1'(run) || evt_error !== 1'(m_err)) begin
            errors++;
            $display("FAIL %s: state=%0d/%0d tx=%0d/%0d held=%0b/%0d t2run=%0b/%0d err=%0b/%0d",
                     tag, state_num, m_st, tx_info, exp_tx(m_st), held, m_hold,
                     t2_running, run, evt_error, m_err);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        model_step();
        #1;
        compare();
    endtask

    task automatic clr();
        tick = 0; i0 = 0; i1 = 0; i3 = 0; act = 0; deact = 0; t1 = 0; fwr = 0; fdata = '0;
    endtask

    task automatic force_wr(logic [4:0] d);
        fwr = 1; fdata = d; cycle(); clr();
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            tick = 1; cycle(); tick = 0; cycle();
        end
    endtask

    task automatic expect_state(int s, string t);
        checks++;
        if (state_num !== 3'(s)) begin
            errors++;
            $display("FAIL %s: state=%0d expected=%0d", t, state_num, s);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: run did not end, expected completion");
        summary();
        $finish;
    end

    initial begin
        cycle(); cycle();
        rst = 0;
        #0;
        tag = "R1"; cycle(); expect_state(0, "R1 reset G0");

        tag = "R5";                               // held in G0
        act = 1; i1 = 1; t1 = 1; cycle(); clr();
        tick = 1; i3 = 1; cycle(); clr();
        expect_state(0, "R5 held G0");

        tag = "R3"; force_wr(5'h00); expect_state(1, "R3 release G0->G1");

        tag = "R6"; i0 = 1; cycle(); clr(); deact = 1; cycle(); clr();
        expect_state(1, "R6 neutral in G1");
        tag = "R11"; i3 = 1; cycle(); clr(); t1 = 1; cycle(); clr();
        tag = "R6"; act = 1; cycle(); clr(); expect_state(2, "R6 act G1->G2");
        tag = "R2"; cycle();
        tag = "R7"; i3 = 1; cycle(); clr(); expect_state(3, "R7 info3 G2->G3");
        tag = "R11"; i1 = 1; cycle(); clr(); t1 = 1; cycle(); clr();
        tag = "R8"; i0 = 1; cycle(); clr(); expect_state(2, "R8 info0 G3->G2");
        i3 = 1; cycle(); clr(); deact = 1; cycle(); clr();
        expect_state(4, "R8 deact G3->G4");

        tag = "R9"; ticks(255); expect_state(4, "R9 before T2 end");
        ticks(1); expect_state(1, "R9 T2 expiry G4->G1");
        ticks(3);

        tag = "R6"; i1 = 1; cycle(); clr(); expect_state(2, "R6 info1 G1->G2");
        tag = "R7"; t1 = 1; cycle(); clr(); expect_state(4, "R7 t1 G2->G4");
        tag = "R9"; act = 1; cycle(); clr(); expect_state(2, "R9 act G4->G2");
        tag = "R7"; deact = 1; cycle(); clr(); expect_state(4, "R7 deact G2->G4");
        tag = "R10"; act = 1; deact = 1; cycle(); clr(); expect_state(4, "R10 deact beats act");
        act = 1; t1 = 1; cycle(); clr(); expect_state(2, "R10 act beats t1");
        t1 = 1; i3 = 1; cycle(); clr(); expect_state(4, "R10 t1 beats info3");
        ticks(100);
        act = 1; i0 = 1; cycle(); clr(); expect_state(2, "R10 act beats info0");
        i3 = 1; i1 = 1; i0 = 1; cycle(); clr(); expect_state(3, "R10 info3 first");

        tag = "R4"; force_wr(5'h13); expect_state(3, "R4 force 13h G3");
        tag = "R5"; i0 = 1; cycle(); clr(); deact = 1; t1 = 1; cycle(); clr();
        expect_state(3, "R5 held G3");
        tag = "R11"; force_wr(5'h17); expect_state(3, "R11 bad force");
        tag = "R3"; force_wr(5'h03); expect_state(3, "R3 release keeps G3");
        tag = "R8"; i0 = 1; cycle(); clr(); expect_state(2, "R8 info0 after release");

        tag = "R4"; force_wr(5'h14); expect_state(4, "R4 force G4");
        tag = "R5"; ticks(300); expect_state(4, "R5 held G4 no T2");
        tag = "R3"; force_wr(5'h04);
        tag = "R9"; ticks(256); expect_state(1, "R9 T2 after release");
        cycle(); cycle();

        summary();
        $finish;
    end
endmodule